// File: doc/BRIEF.md
# Wake-up Cause Interrupt Register

This block records why a device left reset or a low-power state and holds that record for a host. Seven event inputs arrive from the power sequencer and from the press-duration timers. The sequencer reports a start from off, a start from hibernate, a converter-fault reset and a missed watchdog heartbeat. The timers report a long press on the on key, on the power-on pin or on the wakeup pin. Each input is synchronised and edge-detected. A rising edge latches a sticky flag, and the flag stays set until the host reads it.

A mask register selects which flags contribute to one combined wake-up interrupt line. The host reaches both registers through a plain synchronous port that carries an address, write data, a write strobe and a read strobe. Read data is registered and appears one cycle after the strobe. Reading the status register returns the flags and clears them in the same access. An edge that arrives during that access is kept for the next read.

Top module: `wake_cause_irq`

## Requirements
- R1: After reset, status flags, mask bits, `irq_o` and `reg_rdata` are all 0.
- R2: A rising edge on `evt_in[i]` sets status bit i. The bit becomes readable at most four clock edges after the input is first sampled high, and it stays set until a status read.
- R3: An event input held high sets its flag only once. After the flag is cleared, the flag does not set again until the input falls and rises again.
- R4: A read strobe at address 0x1F returns the status flags in bits 6:0 on `reg_rdata` one cycle later and clears every flag it returned.
- R5: If an edge sets a flag in the same cycle as a status read, that read returns the value held before the read, and the flag is still set afterwards.
- R6: Address 0x27 holds the mask, bits 6:0, which is written by a write strobe and read back by a read strobe. A 1 in bit i masks status bit i.
- R7: `irq_o` equals the OR of (status AND NOT mask), registered one cycle after that value.
- R8: Masked sources still latch and read back in the status register.
- R9: Bits 15:7 of both registers read as 0. Writes to 0x1F have no effect. Reads of any other address return 0.
- R10: An event input that is already high when reset is released does not set its flag.
- R11: Status bit map: 6 off-state start, 5 hibernate start, 4 converter-fault reset, 3 watchdog reset, 2 power-on pin held, 1 on key held, 0 wakeup pin held. Bit i maps to `evt_in[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 7 | Asynchronous wake-cause event inputs, bit i feeds status bit i |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Combined first-level wake-up interrupt |

## Verification
Random seven-bit event bursts are paired with random mask values. This shows whether the latched status depends only on the edges and never on the mask, and whether the interrupt follows status AND NOT mask. Directed cases cover the following:
- An input held high across a clear, which separates edge sensing from level sensing.
- An input that is already high at reset release.
- An edge placed exactly on the edge that carries a status read.
- Cycle-exact sampling of the status-to-interrupt delay.

// File: rtl/wake_cause_pkg.sv
// Package: shared sizes and register addresses of the wake-up cause block.
// Assumes the host port uses 8-bit addresses and 16-bit data.
package wake_cause_pkg;
    localparam int NUM_SRC     = 7;
    localparam int DATA_W      = 16;
    localparam int ADDR_W      = 8;
    localparam int SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 8'h1F;
    localparam logic [ADDR_W-1:0] ADDR_MASK   = 8'h27;

    // Bit positions of the wake causes in status and mask.
    localparam int SRC_OFF_START  = 6;
    localparam int SRC_HIB_START  = 5;
    localparam int SRC_CONV_FAULT = 4;
    localparam int SRC_WDOG_RST   = 3;
    localparam int SRC_PWRON_PIN  = 2;
    localparam int SRC_ON_KEY     = 1;
    localparam int SRC_WAKE_PIN   = 0;
endpackage

// File: rtl/wake_evt_detect.sv
// Module: wake_evt_detect
// Synchronises each asynchronous event input through STAGES flops and emits a
// one-cycle pulse on each rising edge. Edge output stays blocked until the sync
// chain and the history flop hold real samples, so an input that is already
// high at reset release produces no pulse.
module wake_evt_detect #(
    parameter int N      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_async,
    output logic [N-1:0] evt_rise
);
    localparam int ARM_CYC = STAGES + 1;
    localparam int CNT_W   = $clog2(ARM_CYC + 1);

    logic [N-1:0]     chain [STAGES];
    logic [N-1:0]     hist_q;
    logic [CNT_W-1:0] arm_cnt;
    logic             armed;

    // Purpose: first synchroniser stage samples the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= evt_async;
    end

    // Further synchroniser stages, generated from STAGES.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Purpose: shift the synchronised value one stage on.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    // Purpose: keep the previous synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= chain[STAGES-1];
    end

    // Purpose: count cycles after reset until the pipeline holds real samples.
    always_ff @(posedge clk) begin
        if (!rst_n)                             arm_cnt <= '0;
        else if (arm_cnt != CNT_W'(ARM_CYC))    arm_cnt <= arm_cnt + 1'b1;
    end

    assign armed = (arm_cnt == CNT_W'(ARM_CYC));

    // Per-source edge decode.
    for (genvar i = 0; i < N; i++) begin : g_edge
        // Purpose: rising edge of source i, suppressed until armed.
        always_comb begin
            evt_rise[i] = armed & chain[STAGES-1][i] & ~hist_q[i];
        end
    end

    // An edge pulse never lasts two cycles (R2, R3).
    p_edge_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_rise) |=> ((evt_rise & $past(evt_rise)) == '0));

    // No edge while the pipeline still holds reset values (R10).
    p_quiet_after_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (evt_rise == '0));
endmodule

// File: rtl/wake_status_bank.sv
// Module: wake_status_bank
// Holds the sticky wake-cause flags. An edge pulse sets a flag. A clear strobe
// from the host port zeroes all flags, except those whose edge arrives in the
// same cycle, which stay set.
module wake_status_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_pulse,
    input  logic         clr_all,
    output logic [N-1:0] status_q
);
    logic [N-1:0] keep;
    logic [N-1:0] status_d;

    // Purpose: select which old flags survive this cycle.
    always_comb begin
        keep = clr_all ? '0 : status_q;
    end

    // Purpose: merge surviving flags with new edges (set wins over clear).
    always_comb begin
        status_d = keep | set_pulse;
    end

    // Purpose: flag storage.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    // A flag stays set without a clear (R2).
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_all |=> ((status_q & $past(status_q)) == $past(status_q)));

    // Every edge lands in the flags (R2, R5).
    p_edge_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_pulse) |=> ((status_q & $past(set_pulse)) == $past(set_pulse)));

    // A clear leaves only flags set by same-cycle edges (R4).
    p_clear_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> ((status_q & ~$past(set_pulse)) == '0));
endmodule

// File: rtl/wake_host_port.sv
// Module: wake_host_port
// Decodes the host register port: owns the mask register, registers read data
// and issues the clear strobe for a status read. Assumes read and write strobes
// last one cycle per access. Writes to the status address are dropped.
module wake_host_port #(
    parameter int                N      = 7,
    parameter int                DW     = 16,
    parameter int                AW     = 8,
    parameter logic [AW-1:0]     A_STAT = 8'h1F,
    parameter logic [AW-1:0]     A_MASK = 8'h27
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr,
    input  logic          rd,
    input  logic [N-1:0]  status,
    output logic [N-1:0]  mask_q,
    output logic          clr_status,
    output logic [DW-1:0] rdata
);
    localparam int PAD_W = DW - N;

    logic          hit_stat;
    logic          hit_mask;
    logic [DW-1:0] rd_mux;
    logic          unused_hi;

    // Purpose: address decode.
    always_comb begin
        hit_stat = (addr == A_STAT);
        hit_mask = (addr == A_MASK);
    end

    // Purpose: a status read clears the flags.
    always_comb begin
        clr_status = rd & hit_stat;
    end

    // Purpose: pick the read value; unused bits and addresses give 0.
    always_comb begin
        rd_mux = '0;
        if (hit_stat)      rd_mux = {{PAD_W{1'b0}}, status};
        else if (hit_mask) rd_mux = {{PAD_W{1'b0}}, mask_q};
    end

    assign unused_hi = ^wdata[DW-1:N];

    // Purpose: mask register, written only at its own address.
    always_ff @(posedge clk) begin
        if (!rst_n)              mask_q <= '0;
        else if (wr && hit_mask) mask_q <= wdata[N-1:0];
    end

    // Purpose: registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_mux;
    end

    // A mask write lands exactly (R6).
    p_mask_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_mask) |=> (mask_q == $past(wdata[N-1:0])));

    // Reads of unmapped addresses return 0 (R9).
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !hit_stat && !hit_mask) |=> (rdata == '0));

    // A status read returns the flags held before the clear (R5).
    p_read_old_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_status |=> (rdata[N-1:0] == $past(status)));
endmodule

// File: rtl/wake_irq_combine.sv
// Module: wake_irq_combine
// Collapses the unmasked flags into a single registered interrupt line.
module wake_irq_combine #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] status,
    input  logic [N-1:0] mask,
    output logic         irq_q
);
    logic [N-1:0] pend;

    // Purpose: flags that are enabled.
    always_comb begin
        pend = status & ~mask;
    end

    // Purpose: registered OR reduction.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |pend;
    end
endmodule

// File: rtl/wake_cause_irq.sv
// Module: wake_cause_irq (top)
// Wake-up cause register: seven synchronised event inputs set sticky flags on
// rising edges. The host reads the flags (the read clears them) and the mask
// over a simple register port. Unmasked flags drive one interrupt line.
// Assumes a single clock domain for the host port; the event inputs may be
// asynchronous.
module wake_cause_irq
    import wake_cause_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    evt_in,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  irq_o
);
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] mask_q;
    logic               clr_status;

    wake_evt_detect #(.N(NUM_SRC), .STAGES(SYNC_STAGES)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_async (evt_in),
        .evt_rise  (rise)
    );

    wake_status_bank #(.N(NUM_SRC)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (rise),
        .clr_all   (clr_status),
        .status_q  (status_q)
    );

    wake_host_port #(
        .N      (NUM_SRC),
        .DW     (DATA_W),
        .AW     (ADDR_W),
        .A_STAT (ADDR_STATUS),
        .A_MASK (ADDR_MASK)
    ) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .wr         (reg_wr),
        .rd         (reg_rd),
        .status     (status_q),
        .mask_q     (mask_q),
        .clr_status (clr_status),
        .rdata      (reg_rdata)
    );

    wake_irq_combine #(.N(NUM_SRC)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status_q),
        .mask   (mask_q),
        .irq_q  (irq_o)
    );

    // The interrupt follows the unmasked flags with one cycle of delay (R7).
    p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == |($past(status_q) & ~$past(mask_q))));

    // Upper read bits stay zero (R9).
    p_rdata_hi_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:NUM_SRC] == '0);
endmodule

// File: tb/wake_cause_irq_test.sv
module wake_cause_irq_test;
    localparam logic [7:0] A_ST = 8'h1F;
    localparam logic [7:0] A_MK = 8'h27;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt_in = '0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    wake_cause_irq uut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    always #2 clk = ~clk;

    function automatic logic exp_irq(input logic [6:0] st, input logic [6:0] mk);
        return |(st & ~mk);
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [15:0] d);
        reg_addr = a; reg_rd = 1'b1;
        tick(1);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            finish_run();
        end
    end

    initial begin
        logic [15:0] d;
        logic [6:0] ev, mk;
        void'($urandom(32'h5EED_0042));
        tick(1);
        do_reset();
        tick(4);

        // R1: reset state
        check("R1 irq", {15'd0, irq_o}, 16'd0);
        check("R1 rdata", reg_rdata, 16'd0);
        rd_reg(A_MK, d); check("R1 mask", d, 16'd0);
        rd_reg(A_ST, d); check("R1 status", d, 16'd0);

        // R2/R7/R11: on-key source (bit 1), cycle-exact irq latency
        evt_in[1] = 1'b1;      // sampled at next edge k
        tick(3);               // after k+2: status set, irq not yet
        check("R7 irq before", {15'd0, irq_o}, 16'd0);
        tick(1);
        check("R7 irq after", {15'd0, irq_o}, 16'd1);
        // R3: held input; read clears; no re-set while high
        rd_reg(A_ST, d); check("R2 R11 onkey bit", d, 16'h0002);
        tick(1);
        check("R4 irq drops", {15'd0, irq_o}, 16'd0);
        tick(6);
        rd_reg(A_ST, d); check("R3 level no reset", d, 16'h0000);
        evt_in[1] = 1'b0; tick(4);
        evt_in[1] = 1'b1; tick(5);
        rd_reg(A_ST, d); check("R3 new edge", d, 16'h0002);
        evt_in[1] = 1'b0; tick(4);

        // R5: edge lands on the cycle of a status read
        evt_in[6] = 1'b1;      // off-state source, edge k next
        tick(2);               // at negedge after k+1; set happens at k+2
        rd_reg(A_ST, d); check("R5 read old value", d, 16'h0000);
        rd_reg(A_ST, d); check("R5 flag kept", d, 16'h0040);
        evt_in[6] = 1'b0; tick(4);

        // R9: status writes ignored, upper bits, unmapped address
        evt_in[4] = 1'b1; tick(5); evt_in[4] = 1'b0; tick(3);
        wr_reg(A_ST, 16'h0000);
        wr_reg(A_MK, 16'hFF80);
        rd_reg(A_MK, d); check("R9 mask upper ignored", d, 16'h0000);
        rd_reg(8'h20, d); check("R9 unmapped", d, 16'h0000);
        rd_reg(A_ST, d); check("R9 status write ignored", d, 16'h0010);

        // R8/R6: masked source latches, irq stays low
        wr_reg(A_MK, 16'h0008);
        evt_in[3] = 1'b1; tick(6); evt_in[3] = 1'b0;
        check("R6 masked irq low", {15'd0, irq_o}, 16'd0);
        rd_reg(A_ST, d); check("R8 masked latches", d, 16'h0008);
        wr_reg(A_MK, 16'h0000);
        tick(4);

        // Random bursts with random masks
        for (int it = 0; it < 40; it++) begin
            ev = 7'($urandom);
            mk = 7'($urandom);
            wr_reg(A_MK, {9'd0, mk});
            evt_in = ev; tick(2);
            evt_in = '0; tick(5);
            check("R7 random irq", {15'd0, irq_o}, {15'd0, exp_irq(ev, mk)});
            rd_reg(A_MK, d); check("R6 random mask", d, {9'd0, mk});
            rd_reg(A_ST, d); check("R2 R8 random status", d, {9'd0, ev});
            rd_reg(A_ST, d); check("R4 random cleared", d, 16'd0);
        end

        // R10: inputs high across reset release give no flag
        evt_in = 7'h7F;
        do_reset();
        tick(8);
        rd_reg(A_ST, d); check("R10 high at release", d, 16'h0000);
        check("R10 irq", {15'd0, irq_o}, 16'd0);
        evt_in = '0; tick(4);
        evt_in[0] = 1'b1; tick(5);
        rd_reg(A_ST, d); check("R10 later edge R11 wake pin", d, 16'h0001);

        done = 1;
        finish_run();
    end
endmodule